// File: doc/BRIEF.md
# Programmable Baud Tick Generator

This block turns a reference clock into the timing strobes a serial transmitter and receiver need. The reference is first divided by a small integer prescaler (1 to 8) and then by a 16-bit integer divisor. The result is a single-cycle `tick` enable, which is the oversampling clock of the serial engines. A second counter groups these ticks into bit periods of 4, 8 or 16 ticks and raises `bit_strobe` on the tick that closes each bit period. With a divisor of 1, no prescaling and 4 ticks per bit, the bit rate reaches one quarter of the reference clock.

Software may rewrite the divisor, prescaler and factor selections at any time. Each stage takes a new setting only when its own count wraps, so a period that has already started always runs to its full length. While `enable` is low, every counter is held at zero and both outputs stay low. When `enable` rises again, the first tick and the first bit strobe come at once, and the programmed periods follow from that point.

Top module: `baud_tick_gen`

## Requirements
- R1: While `rst_n` is low, and after its release until `enable` is first seen high, `tick` and `bit_strobe` are 0.
- R2: One cycle after any clock edge that samples `enable` low, `tick` and `bit_strobe` are 0. Every counter is cleared, so a later enable restarts from the beginning.
- R3: When `enable` is sampled high at an edge after being low, `tick` and `bit_strobe` are both 1 right after that edge.
- R4: Successive rising ticks are spaced P*D clock cycles apart. D is the 16-bit `divisor`, with a value of 0 treated as 1. P is `prescale_sel`+1, where the 3-bit field value v divides by v+1.
- R5: With `divisor`=1 and `prescale_sel`=0, `tick` is high on every cycle while enabled.
- R6: `bit_strobe` rises on every N-th tick, so bit strobes are N*P*D cycles apart. N is encoded by the 2-bit `factor_sel`: 0 gives 4, 1 gives 8, 2 gives 16 and 3 gives 16.
- R7: `bit_strobe` is never high without `tick`. When P*D > 1, each tick lasts exactly one cycle.
- R8: A change of `divisor` in the middle of a period does not change the current period. The new value sets the length of the period that starts at the next tick.
- R9: A change of `factor_sel` in the middle of a bit does not change the current bit. The new value applies from the next bit strobe onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run enable; low clears all counters |
| divisor | input | 16 | Integer divisor, 0 behaves as 1 |
| prescale_sel | input | 3 | Prescale value v, divides by v+1 |
| factor_sel | input | 2 | Ticks per bit: 0→4, 1→8, 2/3→16 |
| tick | output | 1 | Oversampling tick enable |
| bit_strobe | output | 1 | Bit-period strobe, coincident with a tick |

## Verification
Both outputs are registered. The first tick and bit strobe are therefore due in the sample right after the edge that first sees `enable` high. Every later tick is due P*D cycles after the previous one, and every bit strobe N*P*D cycles after the previous one. The bench drives inputs on the falling edge and reads outputs on the next falling edge. It measures spacing with a cycle counter taken at those samples, so each expected gap is an exact cycle count. For the reload cases, the new setting is applied three samples into a period. The bench then expects one more interval of the old length before the new length appears.

// File: rtl/btg_pkg.sv
package btg_pkg;

    localparam int unsigned MAX_FACTOR = 16;
    localparam int unsigned BCNT_W     = $clog2(MAX_FACTOR);

    typedef enum logic [1:0] {
        FACTOR_X4      = 2'd0,
        FACTOR_X8      = 2'd1,
        FACTOR_X16     = 2'd2,
        FACTOR_X16_ALT = 2'd3
    } factor_e;

    // Terminal count (ticks per bit minus one) for a factor selection.
    function automatic logic [BCNT_W-1:0] factor_last(input logic [1:0] sel);
        logic [BCNT_W-1:0] r;
        case (factor_e'(sel))
            FACTOR_X4:  r = BCNT_W'(3);
            FACTOR_X8:  r = BCNT_W'(7);
            default:    r = BCNT_W'(MAX_FACTOR - 1);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/btg_prescaler.sv
module btg_prescaler #(
    parameter int unsigned PRE_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [PRE_W-1:0] sel_i,
    output logic             stb_o
);

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
        logic [PRE_W-1:0] lim;
    } pre_state_t;

    pre_state_t st_d, st_q;
    logic       wrap;

    always_comb begin
        st_d = st_q;
        wrap = en_i && (st_q.cnt == st_q.lim);
        if (!en_i) begin
            st_d = '0;
        end else if (wrap) begin
            st_d.cnt = '0;
            st_d.lim = sel_i;          // new division ratio taken on wrap
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stb_o = wrap;

    AST_PRE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= st_q.lim);  // R4

endmodule

// File: rtl/btg_divider.sv
module btg_divider #(
    parameter int unsigned DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             stb_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             fire_o,
    output logic             tick_o
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic [DIV_W-1:0] lim;
        logic             tick;
    } div_state_t;

    div_state_t       st_d, st_q;
    logic [DIV_W-1:0] eff_last;
    logic             fire;

    always_comb begin
        eff_last = (div_i == '0) ? '0 : div_i - 1'b1;
        fire     = stb_i && (st_q.cnt == st_q.lim);
        st_d     = st_q;
        if (!en_i) begin
            st_d = '0;
        end else if (fire) begin
            st_d.cnt  = '0;
            st_d.lim  = eff_last;      // reload only at terminal count
            st_d.tick = 1'b1;
        end else begin
            st_d.tick = 1'b0;
            if (stb_i) st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fire_o = fire;
    assign tick_o = st_q.tick;

    AST_DIV_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= st_q.lim);  // R4

    AST_DIV_LIM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !fire) |=> $stable(st_q.lim));  // R8

endmodule

// File: rtl/btg_bitcount.sv
module btg_bitcount
    import btg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       fire_i,
    input  logic [1:0] fac_i,
    output logic       bit_o
);

    typedef struct packed {
        logic [BCNT_W-1:0] cnt;
        logic [BCNT_W-1:0] lim;
        logic              bstb;
    } bit_state_t;

    bit_state_t st_d, st_q;
    logic       wrap;

    always_comb begin
        wrap = fire_i && (st_q.cnt == st_q.lim);
        st_d = st_q;
        if (!en_i) begin
            st_d = '0;
        end else if (wrap) begin
            st_d.cnt  = '0;
            st_d.lim  = factor_last(fac_i);   // factor taken at bit boundary
            st_d.bstb = 1'b1;
        end else begin
            st_d.bstb = 1'b0;
            if (fire_i) st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bit_o = st_q.bstb;

    AST_BIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= st_q.lim);  // R6

    AST_FAC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !wrap) |=> $stable(st_q.lim));  // R9

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
    parameter int unsigned DIV_W = 16,
    parameter int unsigned PRE_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [DIV_W-1:0] divisor,
    input  logic [PRE_W-1:0] prescale_sel,
    input  logic [1:0]       factor_sel,
    output logic             tick,
    output logic             bit_strobe
);

    logic pre_stb;
    logic div_fire;

    btg_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (enable),
        .sel_i (prescale_sel),
        .stb_o (pre_stb)
    );

    btg_divider #(.DIV_W(DIV_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (enable),
        .stb_i  (pre_stb),
        .div_i  (divisor),
        .fire_o (div_fire),
        .tick_o (tick)
    );

    btg_bitcount u_bit (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (enable),
        .fire_i (div_fire),
        .fac_i  (factor_sel),
        .bit_o  (bit_strobe)
    );

    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!tick && !bit_strobe));  // R2

    AST_FIRST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(enable) |=> (tick && bit_strobe));  // R3

    AST_BIT_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        bit_strobe |-> tick);  // R7

endmodule

// File: tb/test_baud_tick_gen.sv
module test_baud_tick_gen;

    typedef struct packed {
        logic [15:0] div;
        logic [2:0]  pre;
        logic [1:0]  fac;
        int          tper;
        int          bper;
        int          nper;
    } vec_t;

    // divisor, prescale, factor, tick period, bit period, ticks per bit
    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{16'd1, 3'd0, 2'd0,  1,   4,  4},   // R5 every cycle
        '{16'd3, 3'd0, 2'd2,  3,  48, 16},
        '{16'd5, 3'd1, 2'd1, 10,  80,  8},
        '{16'd0, 3'd0, 2'd1,  1,   8,  8},   // divisor 0 acts as 1
        '{16'd2, 3'd7, 2'd0, 16,  64,  4},
        '{16'd7, 3'd2, 2'd3, 21, 336, 16},   // code 3 -> 16
        '{16'd1, 3'd3, 2'd2,  4,  64, 16}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [15:0] divisor = 16'd1;
    logic [2:0]  prescale_sel = '0;
    logic [1:0]  factor_sel = '0;
    logic        tick;
    logic        bit_strobe;

    int cyc = 0;
    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    baud_tick_gen i_baud_tick_gen (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .divisor      (divisor),
        .prescale_sel (prescale_sel),
        .factor_sel   (factor_sel),
        .tick         (tick),
        .bit_strobe   (bit_strobe)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_tick(output int t);
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (tick) break;
        end
        t = cyc;
    endtask

    task automatic wait_bit(output int t);
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (bit_strobe) break;
        end
        t = cyc;
    endtask

    task automatic start(input logic [15:0] d, input logic [2:0] p, input logic [1:0] f);
        @(negedge clk);
        enable = 1'b0;
        divisor = d;
        prescale_sel = p;
        factor_sel = f;
        repeat (2) @(negedge clk);
        enable = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int t0, t1, t2, ntk, gap, prev;
        // R1: reset state
        repeat (3) @(negedge clk);
        check(!tick && !bit_strobe, "R1 in reset", {tick, bit_strobe}, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(!tick && !bit_strobe, "R1 after reset idle", {tick, bit_strobe}, 0);

        // Vector table
        for (int v = 0; v < NV; v++) begin
            start(VECS[v].div, VECS[v].pre, VECS[v].fac);
            check(tick && bit_strobe, "R3 first pulse", {tick, bit_strobe}, 3);
            t0 = cyc;
            ntk = 0;
            gap = -1;
            prev = 1;
            for (int i = 0; i < 400; i++) begin
                @(negedge clk);
                if (bit_strobe && !tick)
                    check(0, "R7 bit without tick", 0, 1);
                if (tick && prev && VECS[v].tper > 1)
                    check(0, "R7 tick width", 2, 1);
                prev = tick;
                if (tick) begin
                    ntk++;
                    if (gap < 0) gap = cyc - t0;
                end
                if (bit_strobe) break;
            end
            check(gap == VECS[v].tper, "R4 tick period", gap, VECS[v].tper);
            check(cyc - t0 == VECS[v].bper, "R6 bit period", cyc - t0, VECS[v].bper);
            check(ntk == VECS[v].nper, "R6 ticks per bit", ntk, VECS[v].nper);
        end

        // R5: divisor 1, no prescale: tick every enabled cycle
        start(16'd1, 3'd0, 2'd1);
        ntk = 0;
        for (int i = 0; i < 20; i++) begin
            if (tick) ntk++;
            @(negedge clk);
        end
        check(ntk == 20, "R5 continuous tick", ntk, 20);

        // R2: disable silences outputs
        enable = 1'b0;
        ntk = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (tick || bit_strobe) ntk++;
        end
        check(ntk == 0, "R2 quiet when disabled", ntk, 0);

        // R2: re-enable restarts with immediate pulse
        enable = 1'b1;
        @(negedge clk);
        check(tick && bit_strobe, "R2 restart", {tick, bit_strobe}, 3);

        // R8: divisor reload at terminal count
        start(16'd10, 3'd0, 2'd2);
        t0 = cyc;
        repeat (3) @(negedge clk);
        divisor = 16'd4;
        wait_tick(t1);
        check(t1 - t0 == 10, "R8 old period kept", t1 - t0, 10);
        wait_tick(t2);
        check(t2 - t1 == 4, "R8 new period", t2 - t1, 4);

        // R9: factor reload at bit boundary
        start(16'd1, 3'd0, 2'd2);
        t0 = cyc;
        repeat (3) @(negedge clk);
        factor_sel = 2'd0;
        wait_bit(t1);
        check(t1 - t0 == 16, "R9 old bit kept", t1 - t0, 16);
        wait_bit(t2);
        check(t2 - t1 == 4, "R9 new bit", t2 - t1, 4);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule